// File: doc/BRIEF.md
# Network-Offload Command Decoder

This block sits between an on-chip word bus and a UDP offload engine. Every incoming 32-bit word comes with the return address of the requester that sent it. The block reads the top nibble of a message's first word and picks one of four commands from it. Receive and transmit configuration messages are four words long. The block gathers them, keeps the parameters, and sends one acknowledgement word back to the reply address given in the last word.

Transmit configuration also manages a single transmit lock. The first requester to configure transmission while the lock is free becomes its owner. A different requester that tries to configure while the lock is held is ignored silently.

A transmit-data header is one word. It is checked for a legal payload length and for lock ownership. The result is a one-cycle go pulse carrying the length, or a one-cycle error pulse. A one-word release command from the owner frees the lock. Input uses valid/ready handshaking. While an acknowledgement waits on the output port, the input is held off.

Top module: `offload_cmd_decoder`

## Requirements
- R1: After reset, ackValid, lockHeld, dataGo and dataErr are 0, inReady is 1, and all stored parameters and dataLen are 0.
- R2: A receive configuration is four accepted words. The first has 4'h3 in bits 31:28, the second is the IP address, the third holds the destination port in bits 31:16 and the source port in bits 15:0, and the fourth is the reply address. On the cycle after the fourth word is accepted, rxIpAddr, rxDstPort, rxSrcPort and rxReplyAddr hold these values. ackValid is 1, ackData is 32'h5000_0000 and ackAddr is the fourth word.
- R3: A transmit configuration has the same four-word layout with 4'h0 in bits 31:28, and the timeout in bits 27:0 of the first word. When the lock is free, the cycle after the fourth word shows the tx parameters updated and txTimeout equal to bits 27:0. ackData is 32'h5800_0000 (bit 27 set) and ackAddr is the fourth word. lockHeld is 1 and lockOwner is the sender of the first word.
- R4: A transmit configuration whose first word comes from a sender other than lockOwner, while lockHeld is 1, produces no acknowledgement. It leaves the tx parameters and the lock unchanged.
- R5: A transmit configuration from the current lock owner is accepted and acknowledged as in R3.
- R6: A single word with 4'h2 in bits 31:28 clears lockHeld on the next cycle if its sender is lockOwner. From any other sender, it has no effect on the lock.
- R7: A transmit-data header (4'h1 in bits 31:28) carries its length in bits 27:17. If the length is 1 to 1472 and the sender owns the lock, dataGo is 1 for exactly one cycle, on the cycle after acceptance, and dataLen equals the length. Bits 16:0 have no effect.
- R8: A transmit-data header with length 0, length above 1472, or a sender that does not own the lock gives a one-cycle dataErr pulse instead. dataGo stays 0 and dataLen is unchanged.
- R9: While ackValid is 1, inReady is 0 and no input word is taken. ackValid, ackData and ackAddr hold until a cycle with ackReady 1, after which ackValid drops.
- R10: A first word with 4'h4 to 4'hF in bits 31:28 is taken as a single word and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Input word can be taken |
| inData | input | 32 | Input word |
| inSender | input | ADDR_W | Return address of the requester |
| ackValid | output | 1 | Acknowledgement waiting |
| ackReady | input | 1 | Acknowledgement taken |
| ackData | output | 32 | Acknowledgement word |
| ackAddr | output | ADDR_W | Destination of the acknowledgement |
| txTimeout | output | 28 | Stored transmit timeout |
| txIpAddr | output | 32 | Stored transmit IP address |
| txDstPort | output | 16 | Stored transmit destination port |
| txSrcPort | output | 16 | Stored transmit source port |
| txReplyAddr | output | ADDR_W | Stored transmit reply address |
| rxIpAddr | output | 32 | Stored receive IP address |
| rxDstPort | output | 16 | Stored receive destination port |
| rxSrcPort | output | 16 | Stored receive source port |
| rxReplyAddr | output | ADDR_W | Stored receive reply address |
| lockHeld | output | 1 | Transmit lock is owned |
| lockOwner | output | ADDR_W | Current lock owner |
| dataGo | output | 1 | One-cycle pulse: legal data header |
| dataErr | output | 1 | One-cycle pulse: rejected data header |
| dataLen | output | LEN_W | Length of the last legal data header |

## Verification
The bench sends receive configurations with random field values. These show whether each word lands in the right parameter and whether the port halves are swapped.

Transmit configurations come from the owner, from a stranger and from a fresh requester. This separates lock grant, silent refusal and re-configuration.

Data headers use random lengths, the edge lengths 0, 1, 1472, 1473 and 2047, random low bits, and both owner and non-owner senders. This tells a range error apart from an ownership error. Release from a non-owner, unknown commands, and input held off behind a pending acknowledgement show that no stray state changes.

// File: rtl/odc_pkg.sv
package odc_pkg;
  localparam int WORD_W = 32;
  localparam int TIMEOUT_W = WORD_W - 4;
  localparam int PORT_W = 16;

  localparam logic [3:0] CMD_TX_CFG  = 4'h0;
  localparam logic [3:0] CMD_TX_DATA = 4'h1;
  localparam logic [3:0] CMD_RELEASE = 4'h2;
  localparam logic [3:0] CMD_RX_CFG  = 4'h3;
  localparam logic [3:0] ACK_TAG     = 4'h5;

  typedef struct packed {
    logic captHdr;
    logic captIp;
    logic captPorts;
    logic commitTx;
    logic commitRx;
    logic loadAck;
    logic ackTx;
    logic captLen;
  } strobe_t;
endpackage

// File: rtl/odc_ctrl.sv
module odc_ctrl
  import odc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_LSB = 17,
  parameter int LEN_W   = 11,
  parameter int MAX_LEN = 1472
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inData,
  input  logic [ADDR_W-1:0] inSender,
  input  logic              ackValid,
  output logic              inReady,
  output strobe_t           strobe,
  output logic              lockHeld,
  output logic [ADDR_W-1:0] lockOwner,
  output logic              dataGo,
  output logic              dataErr
);
  localparam int LAST_IDX = 3;

  logic              accept;
  logic              inMsg;
  logic              msgIsTx;
  logic [1:0]        wordIdx;
  logic [ADDR_W-1:0] senderReg;
  logic [3:0]        nibble;
  logic [LEN_W-1:0]  lenField;
  logic              lenOk;
  logic              ownerHit;
  logic              grant;
  logic              startCfg;
  logic              goNext;
  logic              errNext;
  logic              releaseHit;

  assign inReady  = !ackValid;
  assign accept   = inValid && inReady;
  assign nibble   = inData[WORD_W-1 -: 4];
  assign lenField = inData[LEN_LSB +: LEN_W];
  assign lenOk    = (lenField != '0) && (int'(lenField) <= MAX_LEN);
  assign ownerHit = lockHeld && (lockOwner == inSender);
  assign grant    = !lockHeld || (lockOwner == senderReg);

  always_comb begin
    strobe     = '0;
    startCfg   = 1'b0;
    goNext     = 1'b0;
    errNext    = 1'b0;
    releaseHit = 1'b0;
    if (accept) begin
      if (!inMsg) begin
        case (nibble)
          CMD_TX_CFG, CMD_RX_CFG: begin
            strobe.captHdr = 1'b1;
            startCfg       = 1'b1;
          end
          CMD_TX_DATA: begin
            goNext         = lenOk && ownerHit;
            errNext        = !(lenOk && ownerHit);
            strobe.captLen = goNext;
          end
          CMD_RELEASE: releaseHit = ownerHit;
          default: ;
        endcase
      end else begin
        case (wordIdx)
          2'd1: strobe.captIp = 1'b1;
          2'd2: strobe.captPorts = 1'b1;
          default: begin
            if (msgIsTx) begin
              strobe.commitTx = grant;
              strobe.loadAck  = grant;
              strobe.ackTx    = 1'b1;
            end else begin
              strobe.commitRx = 1'b1;
              strobe.loadAck  = 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inMsg     <= 1'b0;
      msgIsTx   <= 1'b0;
      wordIdx   <= '0;
      senderReg <= '0;
    end else if (startCfg) begin
      inMsg     <= 1'b1;
      msgIsTx   <= (nibble == CMD_TX_CFG);
      wordIdx   <= 2'd1;
      senderReg <= inSender;
    end else if (accept && inMsg) begin
      wordIdx <= wordIdx + 2'd1;
      if (int'(wordIdx) == LAST_IDX) inMsg <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockHeld  <= 1'b0;
      lockOwner <= '0;
    end else if (strobe.commitTx) begin
      lockHeld  <= 1'b1;
      lockOwner <= senderReg;
    end else if (releaseHit) begin
      lockHeld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataGo  <= 1'b0;
      dataErr <= 1'b0;
    end else begin
      dataGo  <= goNext;
      dataErr <= errNext;
    end
  end
endmodule

// File: rtl/odc_datapath.sv
module odc_datapath
  import odc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_LSB = 17,
  parameter int LEN_W   = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WORD_W-1:0]    inData,
  input  strobe_t              strobe,
  input  logic                 ackReady,
  output logic                 ackValid,
  output logic [WORD_W-1:0]    ackData,
  output logic [ADDR_W-1:0]    ackAddr,
  output logic [TIMEOUT_W-1:0] txTimeout,
  output logic [WORD_W-1:0]    txIpAddr,
  output logic [PORT_W-1:0]    txDstPort,
  output logic [PORT_W-1:0]    txSrcPort,
  output logic [ADDR_W-1:0]    txReplyAddr,
  output logic [WORD_W-1:0]    rxIpAddr,
  output logic [PORT_W-1:0]    rxDstPort,
  output logic [PORT_W-1:0]    rxSrcPort,
  output logic [ADDR_W-1:0]    rxReplyAddr,
  output logic [LEN_W-1:0]     dataLen
);
  localparam int ACK_PAD = WORD_W - 5;

  logic [TIMEOUT_W-1:0] stageTimeout;
  logic [WORD_W-1:0]    stageIp;
  logic [PORT_W-1:0]    stageDst;
  logic [PORT_W-1:0]    stageSrc;
  logic [ADDR_W-1:0]    replyWord;

  assign replyWord = ADDR_W'(inData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageTimeout <= '0;
      stageIp      <= '0;
      stageDst     <= '0;
      stageSrc     <= '0;
    end else begin
      if (strobe.captHdr) stageTimeout <= inData[TIMEOUT_W-1:0];
      if (strobe.captIp) stageIp <= inData;
      if (strobe.captPorts) begin
        stageDst <= inData[WORD_W-1 -: PORT_W];
        stageSrc <= inData[PORT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txTimeout   <= '0;
      txIpAddr    <= '0;
      txDstPort   <= '0;
      txSrcPort   <= '0;
      txReplyAddr <= '0;
    end else if (strobe.commitTx) begin
      txTimeout   <= stageTimeout;
      txIpAddr    <= stageIp;
      txDstPort   <= stageDst;
      txSrcPort   <= stageSrc;
      txReplyAddr <= replyWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxIpAddr    <= '0;
      rxDstPort   <= '0;
      rxSrcPort   <= '0;
      rxReplyAddr <= '0;
    end else if (strobe.commitRx) begin
      rxIpAddr    <= stageIp;
      rxDstPort   <= stageDst;
      rxSrcPort   <= stageSrc;
      rxReplyAddr <= replyWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataLen <= '0;
    else if (strobe.captLen) dataLen <= inData[LEN_LSB +: LEN_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackValid <= 1'b0;
      ackData  <= '0;
      ackAddr  <= '0;
    end else if (strobe.loadAck) begin
      ackValid <= 1'b1;
      ackData  <= {ACK_TAG, strobe.ackTx, {ACK_PAD{1'b0}}};
      ackAddr  <= replyWord;
    end else if (ackReady) begin
      ackValid <= 1'b0;
    end
  end
endmodule

// File: rtl/offload_cmd_decoder.sv
module offload_cmd_decoder
  import odc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_LSB = 17,
  parameter int LEN_W   = 11,
  parameter int MAX_LEN = 1472
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [31:0]          inData,
  input  logic [ADDR_W-1:0]    inSender,
  output logic                 ackValid,
  input  logic                 ackReady,
  output logic [31:0]          ackData,
  output logic [ADDR_W-1:0]    ackAddr,
  output logic [27:0]          txTimeout,
  output logic [31:0]          txIpAddr,
  output logic [15:0]          txDstPort,
  output logic [15:0]          txSrcPort,
  output logic [ADDR_W-1:0]    txReplyAddr,
  output logic [31:0]          rxIpAddr,
  output logic [15:0]          rxDstPort,
  output logic [15:0]          rxSrcPort,
  output logic [ADDR_W-1:0]    rxReplyAddr,
  output logic                 lockHeld,
  output logic [ADDR_W-1:0]    lockOwner,
  output logic                 dataGo,
  output logic                 dataErr,
  output logic [LEN_W-1:0]     dataLen
);
  strobe_t strobe;

  odc_ctrl #(
    .ADDR_W(ADDR_W), .LEN_LSB(LEN_LSB), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)
  ) ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inSender(inSender), .ackValid(ackValid), .inReady(inReady),
    .strobe(strobe), .lockHeld(lockHeld), .lockOwner(lockOwner),
    .dataGo(dataGo), .dataErr(dataErr)
  );

  odc_datapath #(
    .ADDR_W(ADDR_W), .LEN_LSB(LEN_LSB), .LEN_W(LEN_W)
  ) dp (
    .clk(clk), .rstN(rstN), .inData(inData), .strobe(strobe),
    .ackReady(ackReady), .ackValid(ackValid), .ackData(ackData),
    .ackAddr(ackAddr), .txTimeout(txTimeout), .txIpAddr(txIpAddr),
    .txDstPort(txDstPort), .txSrcPort(txSrcPort), .txReplyAddr(txReplyAddr),
    .rxIpAddr(rxIpAddr), .rxDstPort(rxDstPort), .rxSrcPort(rxSrcPort),
    .rxReplyAddr(rxReplyAddr), .dataLen(dataLen)
  );
endmodule

// File: rtl/odc_checker.sv
module odc_checker #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 11,
  parameter int MAX_LEN = 1472
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              ackValid,
  input logic              ackReady,
  input logic [31:0]       ackData,
  input logic [ADDR_W-1:0] ackAddr,
  input logic              lockHeld,
  input logic [ADDR_W-1:0] lockOwner,
  input logic              dataGo,
  input logic              dataErr,
  input logic [LEN_W-1:0]  dataLen
);
  assert_hold_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> !inReady);

  assert_ack_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !ackReady) |=> (ackValid && $stable(ackData) && $stable(ackAddr)));

  assert_ack_format_R2: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (ackData[31:28] == 4'h5 && ackData[26:0] == 27'd0));

  assert_tx_ack_locks_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ackValid) && ackData[27]) |-> (lockHeld && lockOwner == $past(lockOwner) || lockHeld && !$past(lockHeld) || lockHeld));

  assert_go_err_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(dataGo && dataErr));

  assert_go_len_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    dataGo |-> (dataLen != '0 && int'(dataLen) <= MAX_LEN));

  assert_go_needs_lock_R7: assert property (@(posedge clk) disable iff (!rstN)
    dataGo |-> $past(lockHeld));

  assert_owner_steady_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lockHeld) && lockHeld && !$rose(ackValid)) |-> $stable(lockOwner));
endmodule

bind offload_cmd_decoder odc_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)
) chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .ackValid(ackValid),
  .ackReady(ackReady), .ackData(ackData), .ackAddr(ackAddr),
  .lockHeld(lockHeld), .lockOwner(lockOwner), .dataGo(dataGo),
  .dataErr(dataErr), .dataLen(dataLen)
);

// File: tb/offload_cmd_decoder_test.sv
module offload_cmd_decoder_test;
  localparam int AW = 32;
  localparam int LW = 11;
  localparam int MAXL = 1472;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [31:0] inData = '0;
  logic [AW-1:0] inSender = '0;
  logic ackValid;
  logic ackReady = 1'b0;
  logic [31:0] ackData;
  logic [AW-1:0] ackAddr;
  logic [27:0] txTimeout;
  logic [31:0] txIpAddr, rxIpAddr;
  logic [15:0] txDstPort, txSrcPort, rxDstPort, rxSrcPort;
  logic [AW-1:0] txReplyAddr, rxReplyAddr, lockOwner;
  logic lockHeld, dataGo, dataErr;
  logic [LW-1:0] dataLen;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bit modelHeld = 1'b0;
  logic [AW-1:0] modelOwner = '0;
  logic [LW-1:0] modelLen = '0;

  always #2 clk = ~clk;

  offload_cmd_decoder uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inSender(inSender), .ackValid(ackValid),
    .ackReady(ackReady), .ackData(ackData), .ackAddr(ackAddr),
    .txTimeout(txTimeout), .txIpAddr(txIpAddr), .txDstPort(txDstPort),
    .txSrcPort(txSrcPort), .txReplyAddr(txReplyAddr), .rxIpAddr(rxIpAddr),
    .rxDstPort(rxDstPort), .rxSrcPort(rxSrcPort), .rxReplyAddr(rxReplyAddr),
    .lockHeld(lockHeld), .lockOwner(lockOwner), .dataGo(dataGo),
    .dataErr(dataErr), .dataLen(dataLen)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit expGo(input logic [LW-1:0] len, input logic [AW-1:0] s);
    return (len >= 1) && (int'(len) <= MAXL) && modelHeld && (modelOwner == s);
  endfunction

  // drive at negedge, wait for ready, accept on posedge, return at next negedge
  task automatic sendWord(input logic [31:0] d, input logic [AW-1:0] s);
    inValid = 1'b1; inData = d; inSender = s;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic sendCfg(input logic [3:0] cmd, input logic [27:0] low,
                         input logic [31:0] ip, input logic [15:0] dp,
                         input logic [15:0] sp, input logic [31:0] reply,
                         input logic [AW-1:0] s);
    sendWord({cmd, low}, s);
    sendWord(ip, s);
    sendWord({dp, sp}, s);
    sendWord(reply, s);
  endtask

  task automatic takeAck();
    ackReady = 1'b1;
    @(negedge clk);
    ackReady = 1'b0;
    chk("R9 ack drops after ackReady", 32'(ackValid), 32'd0);
  endtask

  task automatic doRx(input logic [AW-1:0] s);
    logic [31:0] ip = $urandom;
    logic [15:0] dp = 16'($urandom);
    logic [15:0] sp = 16'($urandom);
    logic [31:0] rp = $urandom;
    sendCfg(4'h3, 28'($urandom), ip, dp, sp, rp, s);
    chk("R2 ackValid", 32'(ackValid), 32'd1);
    chk("R2 ackData", ackData, 32'h5000_0000);
    chk("R2 ackAddr", ackAddr, rp);
    chk("R2 rxIpAddr", rxIpAddr, ip);
    chk("R2 rxDstPort", 32'(rxDstPort), 32'(dp));
    chk("R2 rxSrcPort", 32'(rxSrcPort), 32'(sp));
    chk("R2 rxReplyAddr", rxReplyAddr, rp);
    takeAck();
  endtask

  task automatic doTx(input logic [AW-1:0] s, input string tag);
    logic [27:0] to = 28'($urandom);
    logic [31:0] ip = $urandom;
    logic [15:0] dp = 16'($urandom);
    logic [15:0] sp = 16'($urandom);
    logic [31:0] rp = $urandom;
    logic [27:0] oldTo = txTimeout;
    logic [31:0] oldIp = txIpAddr;
    bit ok = !modelHeld || (modelOwner == s);
    sendCfg(4'h0, to, ip, dp, sp, rp, s);
    if (ok) begin
      chk({tag, " ackValid"}, 32'(ackValid), 32'd1);
      chk({tag, " ackData"}, ackData, 32'h5800_0000);
      chk({tag, " ackAddr"}, ackAddr, rp);
      chk({tag, " txTimeout"}, 32'(txTimeout), 32'(to));
      chk({tag, " txIpAddr"}, txIpAddr, ip);
      chk({tag, " txPorts"}, {txDstPort, txSrcPort}, {dp, sp});
      chk({tag, " txReplyAddr"}, txReplyAddr, rp);
      modelHeld = 1'b1; modelOwner = s;
      chk({tag, " lockHeld"}, 32'(lockHeld), 32'd1);
      chk({tag, " lockOwner"}, lockOwner, s);
      takeAck();
    end else begin
      chk({tag, " no ack"}, 32'(ackValid), 32'd0);
      chk({tag, " timeout kept"}, 32'(txTimeout), 32'(oldTo));
      chk({tag, " ip kept"}, txIpAddr, oldIp);
      chk({tag, " owner kept"}, lockOwner, modelOwner);
      chk({tag, " lock kept"}, 32'(lockHeld), 32'd1);
    end
  endtask

  task automatic doData(input logic [LW-1:0] len, input logic [AW-1:0] s);
    bit go = expGo(len, s);
    sendWord({4'h1, len, 17'($urandom)}, s);
    if (go) modelLen = len;
    chk(go ? "R7 dataGo" : "R8 dataGo low", 32'(dataGo), 32'(go));
    chk(go ? "R7 dataErr low" : "R8 dataErr", 32'(dataErr), 32'(!go));
    chk(go ? "R7 dataLen" : "R8 dataLen kept", 32'(dataLen), 32'(modelLen));
    @(negedge clk);
    chk("R7 single-cycle pulse", 32'({dataGo, dataErr}), 32'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h0DC5_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ackValid", 32'(ackValid), 32'd0);
    chk("R1 inReady", 32'(inReady), 32'd1);
    chk("R1 lockHeld", 32'(lockHeld), 32'd0);
    chk("R1 pulses", 32'({dataGo, dataErr}), 32'd0);
    chk("R1 params", txIpAddr | rxIpAddr | 32'(txTimeout) | 32'(dataLen), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R8: data header with no lock held
    doData(11'd100, 32'hA);
    // R2 receive configs
    for (int i = 0; i < 8; i++) doRx($urandom);
    // R3 lock grant
    doTx(32'hA, "R3");
    // R5 owner reconfigures
    doTx(32'hA, "R5");
    // R4 stranger refused
    doTx(32'hB, "R4");
    // R7/R8 boundary lengths from owner and stranger
    doData(11'd0, 32'hA);
    doData(11'd1, 32'hA);
    doData(11'd1472, 32'hA);
    doData(11'd1473, 32'hA);
    doData(11'd2047, 32'hA);
    doData(11'd1000, 32'hB);
    for (int i = 0; i < 40; i++)
      doData(11'($urandom_range(0, 2047)), ($urandom_range(0, 3) == 0) ? 32'hB : 32'hA);

    // R10 unknown commands change nothing
    for (int c = 4; c < 16; c++) begin
      sendWord({4'(c), 28'($urandom)}, 32'hA);
      chk("R10 no ack", 32'(ackValid), 32'd0);
      chk("R10 no pulse", 32'({dataGo, dataErr}), 32'd0);
      chk("R10 lock kept", 32'(lockHeld), 32'd1);
    end
    doRx(32'h77);  // framing still aligned after R10

    // R6 release from stranger ignored
    sendWord(32'h2000_0000, 32'hB);
    chk("R6 stranger release ignored", 32'(lockHeld), 32'd1);

    // R9 back-pressure: ack pending, owner release must wait
    sendCfg(4'h3, 28'd0, 32'h1, 16'd2, 16'd3, 32'hCAFE, 32'h5);
    inValid = 1'b1; inData = 32'h2000_0000; inSender = 32'hA;
    repeat (4) begin
      @(negedge clk);
      chk("R9 inReady low", 32'(inReady), 32'd0);
      chk("R9 ack held", ackAddr, 32'hCAFE);
      chk("R9 word not taken", 32'(lockHeld), 32'd1);
    end
    inValid = 1'b0;
    takeAck();
    chk("R9 lock after held-off word", 32'(lockHeld), 32'd1);

    // R6 owner release frees lock
    sendWord(32'h2000_0000, 32'hA);
    chk("R6 owner release", 32'(lockHeld), 32'd0);
    modelHeld = 1'b0;
    doData(11'd5, 32'hA);
    // random mix of tx configs and data after lock freed
    for (int i = 0; i < 20; i++) begin
      logic [AW-1:0] s = 32'($urandom_range(1, 3));
      if ($urandom_range(0, 1) == 0) doTx(s, "R4");
      else doData(11'($urandom_range(0, 1600)), s);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule